// File: doc/BRIEF.md
# Banked GPIO Edge/Level Interrupt Controller

This block turns GPIO input pins into interrupt requests. The pins are split into banks of 32 lines, and each bank has its own interrupt output. Each line has a 4-bit trigger mode that selects rising edge, falling edge, either edge, active-high level or active-low level. A sticky status bit records every detected trigger, whether or not the line is enabled. The bank output is raised for any line whose status bit is set and whose enable bit is set. Software reads the status word of the bank that interrupted, handles every set bit, and clears those bits by writing ones to them.

Before any pin is evaluated it passes through a two-flop synchronizer. Each bank then samples its synchronized pins on its own sample ticks. The bank's debounce register sets the tick rate in two ways:
- it picks one of two tick sources, a slow clock enable or a fast clock enable;
- it sets an exponent n, and the bank takes one sample every 2^n ticks of the chosen source.

Edges are found by comparing the new sample with the previous one.

All registers sit in a flat word-addressed window with combinational read data. Bank b occupies words b*8 to b*8+7.

Top module: `gpio_bank_irq`

## Requirements
- R1: After reset, all enable, status, mode and debounce registers read 0 and every interrupt output is low.
- R2: Mode code 0 (rising) sets the status bit when a sample is 1 and the previous sample was 0, and never on a 1-to-0 change.
- R3: Mode code 1 (falling) sets the status bit when a sample is 0 and the previous sample was 1.
- R4: Mode code 4 (either edge) sets the status bit on any change between consecutive samples.
- R5: Mode codes 2 (high level) and 3 (low level) set the status bit on every sample tick while the sampled level is active, so the bit is set again on the cycle after a clear.
- R6: Mode codes 5 to 15 never set the status bit.
- R7: The mode of line l is held in bits [4*(l%8)+3 : 4*(l%8)] of the bank's mode word l/8, at bank offsets 0 to 3. A write to one mode word leaves the fields in the other words unchanged, and every field reads back as written.
- R8: A status bit is set by its trigger even when the line is disabled. The bank interrupt output equals the OR over the bank's lines of (status AND enable), registered, so it follows an enable write one cycle later.
- R9: At bank offset 5, writing 1 to a status bit clears it and writing 0 leaves it unchanged. If a clear and a trigger of the same line fall in the same cycle, the trigger wins.
- R10: Debounce register (offset 6): bit 0 selects the tick source (0 = slow, 1 = fast) and bits [6:4] hold the exponent n. A write to this register restarts the prescaler, and the 2^n-th tick of the selected source after that write is the first sample tick. Ticks from the other source are ignored.
- R11: Address map: word address = {bank, offset}. Offset 4 is the enable register and offset 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ls_tick_i | input | 1 | Slow sample source, one-cycle clock enable |
| hs_tick_i | input | 1 | Fast sample source, one-cycle clock enable |
| pins_i | input | NUM_BANKS*LINES | GPIO inputs; bank b uses bits [b*LINES +: LINES] |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Read data for reg_addr_i, combinational |
| irq_o | output | NUM_BANKS | Per-bank interrupt request |

## Verification
Wrong internal state shows up in two places: the status word read back from the register port, and the bank interrupt output.
- A wrong sample register or wrong mode decode causes a missing or spurious status bit. This is visible three cycles after the pin changes: two synchronizer stages plus one sample tick.
- A wrong enable or wrong OR reduction shows on irq_o one cycle after status or enable changes.
- A bad prescaler phase moves the first status bit to a different source tick after the debounce write, so the tick count at which the bit appears exposes it.
- Mixing up clear and set priority leaves a level line clear after a clear write while its level is still active.

// File: rtl/gbi_pkg.sv
package gbi_pkg;
  localparam int FIELD_W         = 4;
  localparam int FIELDS_PER_WORD = 8;
  localparam int OFF_W           = 3;

  localparam logic [FIELD_W-1:0] TRIG_RISE = 4'd0;
  localparam logic [FIELD_W-1:0] TRIG_FALL = 4'd1;
  localparam logic [FIELD_W-1:0] TRIG_HIGH = 4'd2;
  localparam logic [FIELD_W-1:0] TRIG_LOW  = 4'd3;
  localparam logic [FIELD_W-1:0] TRIG_BOTH = 4'd4;

  localparam logic [OFF_W-1:0] OFF_EN   = 3'd4;
  localparam logic [OFF_W-1:0] OFF_STAT = 3'd5;
  localparam logic [OFF_W-1:0] OFF_DBC  = 3'd6;
  localparam int               CFG_WORDS_MAX = 4;
endpackage

// File: rtl/gbi_sync.sv
module gbi_sync #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gbi_tick_gen.sv
module gbi_tick_gen #(
  parameter int EXP_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ls_tick_i,
  input  logic             hs_tick_i,
  input  logic             sel_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic             restart_i,
  output logic             tick_o
);
  localparam int CNT_W = (1 << EXP_W) - 1;

  logic [CNT_W-1:0] cnt_q, mask;
  logic             src;

  assign src = sel_i ? hs_tick_i : ls_tick_i;

  always_comb begin
    mask = '0;
    for (int i = 0; i < CNT_W; i++) mask[i] = (i < int'(exp_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (src)       cnt_q <= cnt_q + 1'b1;
  end

  // every 2^n-th source tick after restart
  assign tick_o = src && !restart_i && ((cnt_q & mask) == mask);
endmodule

// File: rtl/gbi_line_trig.sv
module gbi_line_trig
  import gbi_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     tick_i,
  input  logic [LINES-1:0]         pin_i,
  input  logic [LINES*FIELD_W-1:0] mode_i,
  output logic [LINES-1:0]         trig_o
);
  logic [LINES-1:0] samp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     samp_q <= '0;
    else if (tick_i) samp_q <= pin_i;
  end

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic hit;
    always_comb begin
      case (mode_i[l*FIELD_W +: FIELD_W])
        TRIG_RISE: hit = pin_i[l] & ~samp_q[l];
        TRIG_FALL: hit = ~pin_i[l] & samp_q[l];
        TRIG_HIGH: hit = pin_i[l];
        TRIG_LOW:  hit = ~pin_i[l];
        TRIG_BOTH: hit = pin_i[l] ^ samp_q[l];
        default:   hit = 1'b0;
      endcase
    end
    assign trig_o[l] = tick_i & hit;
  end
endmodule

// File: rtl/gbi_bank.sv
module gbi_bank
  import gbi_pkg::*;
#(
  parameter int LINES  = 32,
  parameter int DATA_W = 32,
  parameter int EXP_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LINES-1:0]  pin_s_i,
  input  logic              ls_tick_i,
  input  logic              hs_tick_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic [LINES-1:0]  stat_o,
  output logic [LINES-1:0]  en_o,
  output logic [LINES-1:0]  trig_o,
  output logic [LINES-1:0]  clr_o,
  output logic              tick_o
);
  localparam int MODE_W = LINES * FIELD_W;

  logic [MODE_W-1:0] mode_q;
  logic [LINES-1:0]  en_q, stat_q, clr, trig;
  logic              dsel_q, irq_q, tick, restart;
  logic [EXP_W-1:0]  dexp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      en_q   <= '0;
      dsel_q <= 1'b0;
      dexp_q <= '0;
    end else if (wr_i) begin
      case (off_i)
        OFF_EN:  en_q <= wdata_i[LINES-1:0];
        OFF_DBC: begin
          dsel_q <= wdata_i[0];
          dexp_q <= wdata_i[4 +: EXP_W];
        end
        OFF_STAT: ;
        default: begin
          if (int'(off_i) < CFG_WORDS_MAX) begin
            for (int k = 0; k < FIELDS_PER_WORD; k++) begin
              if (int'(off_i) * FIELDS_PER_WORD + k < LINES)
                mode_q[(int'(off_i) * FIELDS_PER_WORD + k) * FIELD_W +: FIELD_W]
                  <= wdata_i[k*FIELD_W +: FIELD_W];
            end
          end
        end
      endcase
    end
  end

  assign restart = wr_i && (off_i == OFF_DBC);
  assign clr     = (wr_i && (off_i == OFF_STAT)) ? wdata_i[LINES-1:0] : '0;

  gbi_tick_gen #(.EXP_W(EXP_W)) u_tick (
    .clk_i, .rst_ni, .ls_tick_i, .hs_tick_i,
    .sel_i(dsel_q), .exp_i(dexp_q), .restart_i(restart), .tick_o(tick)
  );

  gbi_line_trig #(.LINES(LINES)) u_trig (
    .clk_i, .rst_ni, .tick_i(tick), .pin_i(pin_s_i), .mode_i(mode_q), .trig_o(trig)
  );

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~clr) | trig;
      irq_q  <= |(stat_q & en_q);
    end
  end

  always_comb begin
    rdata_o = '0;
    case (off_i)
      OFF_EN:   rdata_o[LINES-1:0] = en_q;
      OFF_STAT: rdata_o[LINES-1:0] = stat_q;
      OFF_DBC: begin
        rdata_o[0]           = dsel_q;
        rdata_o[4 +: EXP_W]  = dexp_q;
      end
      default: begin
        if (int'(off_i) < CFG_WORDS_MAX) begin
          for (int k = 0; k < FIELDS_PER_WORD; k++) begin
            if (int'(off_i) * FIELDS_PER_WORD + k < LINES)
              rdata_o[k*FIELD_W +: FIELD_W] =
                mode_q[(int'(off_i) * FIELDS_PER_WORD + k) * FIELD_W +: FIELD_W];
          end
        end
      end
    endcase
  end

  assign irq_o  = irq_q;
  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign trig_o = trig;
  assign clr_o  = clr;
  assign tick_o = tick;
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq
  import gbi_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int LINES     = 32,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       ls_tick_i,
  input  logic                       hs_tick_i,
  input  logic [NUM_BANKS*LINES-1:0] pins_i,
  input  logic                       reg_we_i,
  input  logic [ADDR_W-1:0]          reg_addr_i,
  input  logic [DATA_W-1:0]          reg_wdata_i,
  output logic [DATA_W-1:0]          reg_rdata_o,
  output logic [NUM_BANKS-1:0]       irq_o
);
  localparam int BSEL_W = ADDR_W - OFF_W;
  localparam int ALL_W  = NUM_BANKS * LINES;

  logic [ALL_W-1:0]     pins_s, stat_all, en_all, trig_all, clr_all;
  logic [NUM_BANKS-1:0] tick_all;
  logic [BSEL_W-1:0]    bsel;
  logic [OFF_W-1:0]     off;
  logic [DATA_W-1:0]    bank_rd [NUM_BANKS];

  assign bsel = reg_addr_i[ADDR_W-1:OFF_W];
  assign off  = reg_addr_i[OFF_W-1:0];

  gbi_sync #(.W(ALL_W)) u_sync (.clk_i, .rst_ni, .d_i(pins_i), .q_o(pins_s));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gbi_bank #(.LINES(LINES), .DATA_W(DATA_W)) u_bank (
      .clk_i, .rst_ni,
      .wr_i      (reg_we_i && (bsel == BSEL_W'(b))),
      .off_i     (off),
      .wdata_i   (reg_wdata_i),
      .pin_s_i   (pins_s[b*LINES +: LINES]),
      .ls_tick_i, .hs_tick_i,
      .rdata_o   (bank_rd[b]),
      .irq_o     (irq_o[b]),
      .stat_o    (stat_all[b*LINES +: LINES]),
      .en_o      (en_all[b*LINES +: LINES]),
      .trig_o    (trig_all[b*LINES +: LINES]),
      .clr_o     (clr_all[b*LINES +: LINES]),
      .tick_o    (tick_all[b])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (bsel == BSEL_W'(b)) reg_rdata_o = bank_rd[b];
  end
endmodule

// File: rtl/gbi_chk.sv
module gbi_chk #(
  parameter int NUM_BANKS = 2,
  parameter int LINES     = 32
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [NUM_BANKS-1:0]       irq_o,
  input logic [NUM_BANKS*LINES-1:0] stat_all,
  input logic [NUM_BANKS*LINES-1:0] en_all,
  input logic [NUM_BANKS*LINES-1:0] trig_all,
  input logic [NUM_BANKS*LINES-1:0] clr_all,
  input logic [NUM_BANKS-1:0]       tick_all
);
  logic [NUM_BANKS-1:0] any_v;
  always_comb
    for (int b = 0; b < NUM_BANKS; b++)
      any_v[b] = |(stat_all[b*LINES +: LINES] & en_all[b*LINES +: LINES]);

  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (stat_all == '0 && en_all == '0 && irq_o == '0));

  // R8
  irq_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past(any_v));

  // R9
  w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_all & $past(clr_all & ~trig_all)) == '0);

  // R9
  trig_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~stat_all & $past(trig_all)) == '0);

  // R8
  no_spurious_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_all & ~$past(stat_all) & ~$past(trig_all)) == '0);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_b
    // R10
    hold_between_ticks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!$past(tick_all[b]) && $past(clr_all[b*LINES +: LINES]) == '0)
        |-> $stable(stat_all[b*LINES +: LINES]));
  end
endmodule

bind gpio_bank_irq gbi_chk #(.NUM_BANKS(NUM_BANKS), .LINES(LINES)) u_chk (.*);

// File: tb/tb_gpio_bank_irq.sv
module tb_gpio_bank_irq;
  localparam int NB = 2, L = 32, DW = 32, AW = 6;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          ls_tick = 1'b0, hs_tick = 1'b0, we = 1'b0;
  logic [NB*L-1:0] pins = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic [NB-1:0] irq;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  gpio_bank_irq #(.NUM_BANKS(NB), .LINES(L), .DATA_W(DW), .ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ls_tick_i(ls_tick), .hs_tick_i(hs_tick),
    .pins_i(pins), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] ra(input int b, input int off);
    return AW'(b * 8 + off);
  endfunction

  task automatic wr(input int b, input int off, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = ra(b, off); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int b, input int off, output logic [31:0] d);
    addr = ra(b, off);
    #1 d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected status after clear at prev, then move to nxt
  function automatic logic [31:0] exp_stat(input logic [127:0] modes, input logic [31:0] p, input logic [31:0] n);
    logic [31:0] e = '0;
    for (int l = 0; l < 32; l++) begin
      case (modes[l*4 +: 4])
        4'd0: e[l] = ~p[l] & n[l];
        4'd1: e[l] = p[l] & ~n[l];
        4'd2: e[l] = p[l] | n[l];
        4'd3: e[l] = ~p[l] | ~n[l];
        4'd4: e[l] = p[l] ^ n[l];
        default: e[l] = 1'b0;
      endcase
    end
    return e;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d, pv, nv, en, e;
    logic [127:0] modes;
    void'($urandom(32'h1234_5eed));
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1, R11: reset values and reserved word
    for (int b = 0; b < NB; b++)
      for (int o = 0; o < 8; o++) begin
        rd(b, o, d);
        check(d == 0, (o == 7) ? "R11" : "R1", d, 0);
      end
    check(irq == 0, "R1", 32'(irq), 0);

    // R7, R11: mode word isolation
    wr(0, 2, 32'h1234_5678);
    rd(0, 2, d); check(d == 32'h1234_5678, "R7", d, 32'h1234_5678);
    rd(0, 1, d); check(d == 0, "R7", d, 0);
    rd(0, 3, d); check(d == 0, "R7", d, 0);
    rd(1, 2, d); check(d == 0, "R11", d, 0);
    wr(0, 2, 0);

    // fast sampling on both banks
    hs_tick = 1'b1;
    wr(0, 6, 32'h1); wr(1, 6, 32'h1);
    rd(1, 6, d); check(d == 32'h1, "R10", d, 1);

    // R2, R8, R9 on bank0 line3 (mode 0)
    pins[3] = 1'b1; idle(6);
    rd(0, 5, d); check(d == 32'h8, "R2", d, 32'h8);
    check(irq[0] == 1'b0, "R8", 32'(irq), 0);
    wr(0, 5, 32'h0);
    rd(0, 5, d); check(d == 32'h8, "R9", d, 32'h8);
    wr(0, 4, 32'h8);
    check(irq[0] == 1'b0, "R8", 32'(irq), 0);
    idle(1);
    check(irq[0] == 1'b1, "R8", 32'(irq), 1);
    wr(0, 5, 32'h8);
    rd(0, 5, d); check(d == 0, "R9", d, 0);
    idle(1);
    check(irq[0] == 1'b0, "R8", 32'(irq), 0);
    pins[3] = 1'b0; idle(6);
    rd(0, 5, d); check(d == 0, "R2", d, 0);

    // R3 line3 falling
    wr(0, 0, 32'h0000_1000);
    pins[3] = 1'b1; idle(6);
    rd(0, 5, d); check(d == 0, "R3", d, 0);
    pins[3] = 1'b0; idle(6);
    rd(0, 5, d); check(d == 32'h8, "R3", d, 32'h8);
    wr(0, 5, 32'hFFFF_FFFF);

    // R5, R9 level high on line0: trigger wins over clear
    wr(0, 0, 32'h0000_0002);
    pins[0] = 1'b1; idle(6);
    wr(0, 5, 32'hFFFF_FFFF);
    rd(0, 5, d); check(d == 32'h1, "R5", d, 1);
    pins[0] = 1'b0; idle(6);
    wr(0, 5, 32'hFFFF_FFFF);
    rd(0, 5, d); check(d == 0, "R5", d, 0);

    // R6: reserved mode code 7 ignores both edges
    wr(0, 0, 32'h0000_0007);
    pins[0] = 1'b1; idle(6); pins[0] = 1'b0; idle(6);
    rd(0, 5, d); check(d == 0, "R6", d, 0);
    wr(0, 0, 32'h0);

    // R10: bank1 slow source, exponent 2; fast ticks must be ignored
    wr(1, 6, 32'h20);
    pins[L+5] = 1'b1; idle(4);
    for (int t = 0; t < 3; t++) begin
      ls_tick = 1'b1; idle(1); ls_tick = 1'b0; idle(1);
    end
    idle(3);
    rd(1, 5, d); check(d == 0, "R10", d, 0);
    ls_tick = 1'b1; idle(1); ls_tick = 1'b0; idle(2);
    rd(1, 5, d); check(d == 32'h20, "R10", d, 32'h20);
    wr(1, 6, 32'h1);
    pins[L+5] = 1'b0; idle(6);
    wr(1, 5, 32'hFFFF_FFFF);

    // random modes, pins and enables (R2..R6, R8)
    for (int it = 0; it < 40; it++) begin
      int b = it % 2;
      pv = pins[b*L +: L];
      for (int w = 0; w < 4; w++) begin
        d = $urandom();
        if (it < 6) d = d & 32'h4444_4444;
        modes[w*32 +: 32] = d;
        wr(b, w, d);
      end
      en = $urandom();
      wr(b, 4, en);
      wr(b, 5, 32'hFFFF_FFFF);
      nv = $urandom();
      pins[b*L +: L] = nv;
      idle(6);
      e = exp_stat(modes, pv, nv);
      rd(b, 5, d);
      check(d == e, "R4 R5 R6 random status", d, e);
      check(irq[b] == |(e & en), "R8 random irq", 32'(irq[b]), 32'(|(e & en)));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule